// File: doc/BRIEF.md
# Separable 5/3 Wavelet Tile Transform (One Level, 2-D)

This block computes one level of the two-dimensional forward 5/3 discrete wavelet transform on a square tile of N×N signed samples. Samples enter in raster order through a valid/ready handshake. Each completed row is split into its even and odd samples. These feed a 5-tap low-pass unit and a 3-tap high-pass unit, which work by direct convolution. The decimated row results are written into an on-chip transpose store. The low half of each row goes to positions 0..N/2-1 and the high half to positions N/2..N-1.

When all N rows have been stored, the same split and filter structure runs down each column of the store. It emits one coefficient per cycle, and each coefficient carries a two-bit subband tag and its row and column position inside that subband. Deeper decomposition is left to an outside controller: it feeds the LL quarter back in as a new tile of half the size, built with a smaller N.

Top module: `dwt53_2d`

## Requirements
- R1: After a clock edge with `rst` high, `out_valid` is 0 and `in_ready` is 1.
- R2: One sample is taken at every rising edge where `in_valid` and `in_ready` are both 1. Samples arrive row by row (row 0 columns 0..N-1 first), idle cycles on `in_valid` are allowed, and the N·N-th taken sample completes the tile.
- R3: `in_ready` is 0 from the edge that takes a tile's last sample until the cycle after that tile's last output. `in_valid` asserted while `in_ready` is 0 takes nothing and leaves the next tile's results unchanged.
- R4: The low-pass output at even position 2k is (-x[2k-2] + 2x[2k-1] + 6x[2k] + 2x[2k+1] - x[2k+2] + 4), arithmetically shifted right by 3.
- R5: The high-pass output at odd position 2k+1 is (-x[2k] + 2x[2k+1] - x[2k+2] + 1), arithmetically shifted right by 1.
- R6: Outside the tile, samples are mirrored about the edge sample without repeating it (x[-i] = x[i], x[N-1+i] = x[N-1-i]). This holds in both the row and the column pass.
- R7: Rows are filtered first. Row r's intermediate holds low results at positions 0..N/2-1 and high results at N/2..N-1. Each intermediate column is then filtered. Intermediates keep DW+2 bits and outputs DW+4 bits, so results stay exact for full-scale inputs.
- R8: Outputs are ordered by intermediate column c = 0..N-1, then by k ascending within a column, with the low result before the high result. `out_band` bit 1 is 1 when c ≥ N/2 and bit 0 is 1 for the column high-pass result (00 = LL, 01 = LH, 10 = HL, 11 = HH). `out_row` = k and `out_col` = c mod N/2.
- R9: Each tile yields exactly N·N outputs, N/2×N/2 per subband, on consecutive cycles. Consecutive tiles are independent of each other.
- R10: A tile in which every sample equals v gives v for every LL coefficient and 0 for every coefficient of the other three subbands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output coefficient present |
| out_band | output | 2 | Subband tag (00 LL, 01 LH, 10 HL, 11 HH) |
| out_row | output | log2(N/2) | Row index inside the subband |
| out_col | output | log2(N/2) | Column index inside the subband |
| out_data | output | DW+4 | Signed coefficient |

## Verification
The bench builds the block with its defaults, N = 8 and DW = 16. With N = 8, each row and column has only four output positions, so mirroring is exercised at both edges on every line: position k = 0 mirrors at the left, and k = N/2-1 mirrors at the right. The 16-bit width allows full-scale alternating tiles that drive both intermediate and final sums to their extreme values. The small tile also keeps each run to a few hundred cycles, which leaves room for impulses at opposite corners, constant tiles, random tiles with input gaps, and a tile that follows stray `in_valid` activity during draining.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        BAND_LL = 2'b00,
        BAND_LH = 2'b01,
        BAND_HL = 2'b10,
        BAND_HH = 2'b11
    } band_e;

    localparam int LP_SHIFT = 3;
    localparam int LP_BIAS  = 4;
    localparam int HP_SHIFT = 1;
    localparam int HP_BIAS  = 1;

    // Whole-sample symmetric reflection of an index into 0..len-1.
    function automatic int mirror_idx(input int idx, input int len);
        if (idx < 0)
            return -idx;
        else if (idx > len - 1)
            return 2 * (len - 1) - idx;
        else
            return idx;
    endfunction

endpackage

// File: rtl/dwt53_split.sv
module dwt53_split
    import dwt53_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic [N-1:0][W-1:0]     line,
    input  logic [$clog2(N/2)-1:0]  pos,
    output logic signed [W-1:0]     ev_prev,
    output logic signed [W-1:0]     ev_cur,
    output logic signed [W-1:0]     ev_next,
    output logic signed [W-1:0]     od_prev,
    output logic signed [W-1:0]     od_next
);
    localparam int NW = $clog2(N);

    // Demultiplex the line around output position pos: even stream
    // (2k-2, 2k, 2k+2) and odd stream (2k-1, 2k+1), edges mirrored.
    always_comb begin
        int base;
        base    = 2 * int'(pos);
        ev_prev = $signed(line[NW'(mirror_idx(base - 2, N))]);
        ev_cur  = $signed(line[NW'(mirror_idx(base,     N))]);
        ev_next = $signed(line[NW'(mirror_idx(base + 2, N))]);
        od_prev = $signed(line[NW'(mirror_idx(base - 1, N))]);
        od_next = $signed(line[NW'(mirror_idx(base + 1, N))]);
    end

endmodule

// File: rtl/dwt53_lowpass.sv
module dwt53_lowpass
    import dwt53_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] t_m2,
    input  logic signed [W-1:0] t_m1,
    input  logic signed [W-1:0] t_0,
    input  logic signed [W-1:0] t_p1,
    input  logic signed [W-1:0] t_p2,
    output logic signed [W+1:0] y
);
    localparam int SW = W + 5;

    logic signed [SW-1:0] acc;

    always_comb begin
        acc = (SW'(t_0) <<< 2) + (SW'(t_0) <<< 1)
            + ((SW'(t_m1) + SW'(t_p1)) <<< 1)
            - SW'(t_m2) - SW'(t_p2)
            + SW'(LP_BIAS);
        y = (W+2)'(acc >>> LP_SHIFT);
    end

    // R10: unit DC gain of the low-pass kernel
    always_comb begin
        if (t_m2 == t_0 && t_m1 == t_0 && t_p1 == t_0 && t_p2 == t_0)
            a_r10_lp_dc_gain: assert (y == (W+2)'(t_0));
    end

endmodule

// File: rtl/dwt53_highpass.sv
module dwt53_highpass
    import dwt53_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] t_m1,
    input  logic signed [W-1:0] t_0,
    input  logic signed [W-1:0] t_p1,
    output logic signed [W+1:0] y
);
    localparam int SW = W + 3;

    logic signed [SW-1:0] acc;

    always_comb begin
        acc = (SW'(t_0) <<< 1) - SW'(t_m1) - SW'(t_p1) + SW'(HP_BIAS);
        y   = (W+2)'(acc >>> HP_SHIFT);
    end

    // R10: the high-pass kernel rejects a constant
    always_comb begin
        if (t_m1 == t_0 && t_p1 == t_0)
            a_r10_hp_dc_reject: assert (y == '0);
    end

endmodule

// File: rtl/dwt53_2d.sv
module dwt53_2d
    import dwt53_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DW-1:0]           in_data,
    output logic                    out_valid,
    output logic [1:0]              out_band,
    output logic [$clog2(N/2)-1:0]  out_row,
    output logic [$clog2(N/2)-1:0]  out_col,
    output logic [DW+3:0]           out_data
);
    localparam int K  = N / 2;
    localparam int KW = $clog2(K);
    localparam int NW = $clog2(N);
    localparam int IW = DW + 2;
    localparam int OW = DW + 4;

    phase_e          phase;
    logic [NW-1:0]   col_cnt;
    logic [NW-1:0]   row_cnt;
    logic [NW-1:0]   c_cnt;
    logic [KW-1:0]   k_cnt;
    logic            ph_hi;
    logic            take;

    logic [N-1:0][DW-1:0] row_buf;
    logic [IW-1:0]        tbuf [N][N];
    logic [N-1:0][IW-1:0] col_line;

    logic signed [DW-1:0] r_ep, r_ec, r_en, r_op, r_on;
    logic signed [IW-1:0] r_lo, r_hi;
    logic signed [IW-1:0] c_ep, c_ec, c_en, c_op, c_on;
    logic signed [OW-1:0] c_lo, c_hi;

    assign in_ready = (phase == PH_LOAD) && !out_valid;
    assign take     = in_valid && in_ready;

    // ---------------- row pass datapath ----------------
    dwt53_split #(.W(DW), .N(N)) u_row_split (
        .line(row_buf), .pos(k_cnt),
        .ev_prev(r_ep), .ev_cur(r_ec), .ev_next(r_en),
        .od_prev(r_op), .od_next(r_on)
    );

    dwt53_lowpass #(.W(DW)) u_row_lp (
        .t_m2(r_ep), .t_m1(r_op), .t_0(r_ec), .t_p1(r_on), .t_p2(r_en), .y(r_lo)
    );

    dwt53_highpass #(.W(DW)) u_row_hp (
        .t_m1(r_ec), .t_0(r_on), .t_p1(r_en), .y(r_hi)
    );

    // ---------------- column pass datapath ----------------
    for (genvar gr = 0; gr < N; gr++) begin : g_col_gather
        assign col_line[gr] = tbuf[gr][c_cnt];
    end

    dwt53_split #(.W(IW), .N(N)) u_col_split (
        .line(col_line), .pos(k_cnt),
        .ev_prev(c_ep), .ev_cur(c_ec), .ev_next(c_en),
        .od_prev(c_op), .od_next(c_on)
    );

    dwt53_lowpass #(.W(IW)) u_col_lp (
        .t_m2(c_ep), .t_m1(c_op), .t_0(c_ec), .t_p1(c_on), .t_p2(c_en), .y(c_lo)
    );

    dwt53_highpass #(.W(IW)) u_col_hp (
        .t_m1(c_ec), .t_0(c_on), .t_p1(c_en), .y(c_hi)
    );

    // ---------------- storage (no reset) ----------------
    always_ff @(posedge clk) begin
        if (take)
            row_buf[col_cnt] <= in_data;
        if (phase == PH_ROW) begin
            tbuf[row_cnt][{1'b0, k_cnt}] <= r_lo;
            tbuf[row_cnt][{1'b1, k_cnt}] <= r_hi;
        end
    end

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_LOAD;
            col_cnt   <= '0;
            row_cnt   <= '0;
            c_cnt     <= '0;
            k_cnt     <= '0;
            ph_hi     <= 1'b0;
            out_valid <= 1'b0;
            out_band  <= BAND_LL;
            out_row   <= '0;
            out_col   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (phase)
                PH_LOAD: begin
                    if (take) begin
                        if (col_cnt == NW'(N - 1)) begin
                            col_cnt <= '0;
                            phase   <= PH_ROW;
                        end else begin
                            col_cnt <= col_cnt + 1'b1;
                        end
                    end
                end
                PH_ROW: begin
                    if (k_cnt == KW'(K - 1)) begin
                        k_cnt <= '0;
                        if (row_cnt == NW'(N - 1)) begin
                            row_cnt <= '0;
                            phase   <= PH_COL;
                        end else begin
                            row_cnt <= row_cnt + 1'b1;
                            phase   <= PH_LOAD;
                        end
                    end else begin
                        k_cnt <= k_cnt + 1'b1;
                    end
                end
                PH_COL: begin
                    out_valid <= 1'b1;
                    out_band  <= {c_cnt[NW-1], ph_hi};
                    out_row   <= k_cnt;
                    out_col   <= c_cnt[KW-1:0];
                    out_data  <= ph_hi ? c_hi : c_lo;
                    ph_hi     <= ~ph_hi;
                    if (ph_hi) begin
                        if (k_cnt == KW'(K - 1)) begin
                            k_cnt <= '0;
                            if (c_cnt == NW'(N - 1)) begin
                                c_cnt <= '0;
                                phase <= PH_LOAD;
                            end else begin
                                c_cnt <= c_cnt + 1'b1;
                            end
                        end else begin
                            k_cnt <= k_cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [2*NW:0] emit_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            emit_cnt <= '0;
        else if (out_valid)
            emit_cnt <= (out_band == BAND_HH && out_row == KW'(K - 1) &&
                         out_col == KW'(K - 1)) ? '0 : emit_cnt + 1'b1;
    end

    a_r9_tile_output_count: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_band == BAND_HH && out_row == KW'(K - 1) && out_col == KW'(K - 1))
        |-> (emit_cnt == (2*NW+1)'(N * N - 1)));

    a_r8_high_follows_low: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_band[0])
        |=> (out_valid && out_band[0] && $stable(out_row) && $stable(out_col) && $stable(out_band[1])));

    a_r3_no_take_while_emitting: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r2_take_only_when_loading: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (phase == PH_LOAD || phase == PH_ROW));

endmodule

// File: tb/sim_dwt53_2d.sv
module sim_dwt53_2d;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int K  = N / 2;
    localparam int KW = $clog2(K);

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_ready;
    logic [DW-1:0]   in_data;
    logic            out_valid;
    logic [1:0]      out_band;
    logic [KW-1:0]   out_row;
    logic [KW-1:0]   out_col;
    logic [DW+3:0]   out_data;

    int checks = 0;
    int errors = 0;

    int tile  [N][N];
    int inter [N][N];

    always #5 clk = ~clk;

    dwt53_2d #(.N(N), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_band(out_band),
        .out_row(out_row), .out_col(out_col), .out_data(out_data)
    );

    function automatic int mir(input int i);
        if (i < 0) return -i;
        if (i > N - 1) return 2 * (N - 1) - i;
        return i;
    endfunction

    function automatic int lp5(input int a, input int b, input int c, input int d, input int e);
        return (-a + 2*b + 6*c + 2*d - e + 4) >>> 3;
    endfunction

    function automatic int hp3(input int a, input int b, input int c);
        return (-a + 2*b - c + 1) >>> 1;
    endfunction

    // Row pass of the model (R4, R5, R6, R7)
    task automatic build_model();
        for (int r = 0; r < N; r++)
            for (int k = 0; k < K; k++) begin
                inter[r][k] = lp5(tile[r][mir(2*k-2)], tile[r][mir(2*k-1)], tile[r][2*k],
                                  tile[r][2*k+1], tile[r][mir(2*k+2)]);
                inter[r][K+k] = hp3(tile[r][2*k], tile[r][2*k+1], tile[r][mir(2*k+2)]);
            end
    endtask

    function automatic int expect_val(input int c, input int k, input int hi);
        if (hi != 0)
            return hp3(inter[2*k][c], inter[2*k+1][c], inter[mir(2*k+2)][c]);
        return lp5(inter[mir(2*k-2)][c], inter[mir(2*k-1)][c], inter[2*k][c],
                   inter[2*k+1][c], inter[mir(2*k+2)][c]);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_tile(input bit gaps);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                if (gaps && ((r * N + c) % 3 == 1)) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_data  = DW'(tile[r][c]);
                while (!in_ready) @(negedge clk);
                @(posedge clk);
            end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Collect N*N outputs and compare with the model; optionally hold
    // in_valid high with junk while the block drains (R3).
    task automatic collect(input string req, input bit junk);
        int got = 0;
        int waited = 0;
        bit ready_bad = 0;
        bit gap_bad = 0;
        bit started = 0;
        if (junk) begin
            in_valid = 1'b1;
            in_data  = 16'h7FFF;
        end
        while (got < N * N && waited < 8 * N * N) begin
            @(negedge clk);
            waited++;
            if (in_ready) ready_bad = 1;
            if (started && !out_valid) gap_bad = 1;
            if (out_valid) begin
                int c, k, hi, ev, eb;
                started = 1;
                c  = got / (2 * K);
                k  = (got / 2) % K;
                hi = got % 2;
                ev = expect_val(c, k, hi);
                eb = ((c >= K) ? 2 : 0) + hi;
                check(int'($signed(out_data)) == ev, req, "coefficient", int'($signed(out_data)), ev);
                check(int'(out_band) == eb && int'(out_row) == k && int'(out_col) == c % K,
                      "R8", "band/row/col",
                      int'(out_band) * 100 + int'(out_row) * 10 + int'(out_col),
                      eb * 100 + k * 10 + c % K);
                got++;
                if (got == N * N) in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        check(got == N * N, "R9", "output count", got, N * N);
        check(!gap_bad, "R9", "outputs on consecutive cycles", int'(gap_bad), 0);
        check(!ready_bad, "R3", "in_ready low while draining", int'(ready_bad), 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R3", "in_ready after drain", int'(in_ready), 1);
    endtask

    task automatic run_tile(input string req, input bit gaps, input bit junk);
        build_model();
        drive_tile(gaps);
        collect(req, junk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic test_constant(input int v);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) tile[r][c] = v;
        run_tile("R10", 1'b0, 1'b0);
        // Model-free confirmation of the constant-tile rule
        check(inter[0][0] == v && inter[0][K] == 0, "R10", "constant row pass", inter[0][0], v);
    endtask

    task automatic test_impulse(input int pr, input int pc, input int amp);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) tile[r][c] = 0;
        tile[pr][pc] = amp;
        run_tile("R6", 1'b0, 1'b0);
    endtask

    task automatic test_full_scale();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                tile[r][c] = (((r + c) % 2) == 0) ? 32767 : -32768;
        run_tile("R7", 1'b0, 1'b0);
    endtask

    task automatic test_random(input bit gaps, input bit junk, input string req);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                tile[r][c] = int'($signed(16'($urandom)));
        run_tile(req, gaps, junk);
    endtask

    initial begin
        test_reset();
        test_constant(1234);
        test_constant(-777);
        test_impulse(0, 0, 1000);
        test_impulse(N - 1, N - 1, -2048);
        test_impulse(3, 4, 513);
        test_full_scale();
        test_random(1'b1, 1'b0, "R2");
        test_random(1'b0, 1'b1, "R3");
        test_random(1'b0, 1'b0, "R4");
        test_random(1'b1, 1'b0, "R5");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual cycles %0d expected fewer than %0d", 100000, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule